// File: doc/BRIEF.md
# Round-Robin Arbiter with Time Slices

This block shares one resource among four requesters. Each requester raises its own request line and is granted the resource in turn. The grant vector is registered and has at most one bit high. A requester that wins the grant keeps it for a time slice of up to four clock cycles, which a two-bit counter measures. When the slice runs out, the grant passes to the next requester in circular index order that is asking. If that search finds no other requester, the same holder keeps the grant and a fresh slice starts.

A holder that drops its request gives up the unused part of its slice straight away. In the next cycle the grant moves to the next active requester, or clears when nobody is asking. No index has fixed priority, so every requester that holds its request line is served within three slices of the others.

Top module: `rr_slice_arbiter`

## Requirements
- R1: A synchronous active-high reset clears the grant and the slice counter. The first search after reset starts at requester 0, so if all four lines request together the grant becomes 4'b0001.
- R2: The grant vector never has more than one bit high. The cycle after an edge that samples no request at all, the grant is 4'b0000.
- R3: The grant is registered. A request sampled at a clock edge when no grant is held shows on the grant output after that same edge, one cycle of latency.
- R4: When the grant is handed over, the search starts at the index after the current holder and wraps from 3 to 0. The first requesting index found wins.
- R5: A holder whose request stays high keeps the grant for exactly four consecutive cycles when another requester is waiting. It then loses the grant.
- R6: If the holder's request is low at a clock edge, the grant moves at that edge to the next requesting index after the holder, or to 4'b0000 if nobody is requesting.
- R7: The slice counter restarts from zero whenever the grant changes hands, so a new holder always gets a full four-cycle slice.
- R8: A holder whose slice expires while no other input is requesting keeps the grant without a gap, and its counter restarts.
- R9: After the grant has been idle, the search starts at the index after the last requester that held the grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 4 | Request lines, one per requester |
| grant | output | 4 | One-hot grant, bit i serves request i |

## Verification
The hardest case to reach is an early release that lands part way through a slice while other requesters are waiting. The stimulus has to drop exactly the holder's line at a chosen cycle. It then has to show that the next holder gets a full four cycles instead of the leftover count. A second corner is the search pointer after an idle gap, which only matters if the last holder left while it was the only requester.

Directed sequences set up both cases at known cycles. Long runs of sticky random request patterns then reach the remaining mixes of expiry, drops and idle gaps. A behavioural model compares the grant on every cycle.

// File: rtl/rr_pkg.sv
package rr_pkg;
  localparam int RR_NREQ_DEFAULT  = 4;
  localparam int RR_CNT_W_DEFAULT = 2;

  // number of cycles in one slice for a given counter width
  function automatic int slice_cycles(input int cnt_w);
    return 1 << cnt_w;
  endfunction

  typedef enum logic [1:0] {
    RR_KEEP    = 2'd0,
    RR_EXPIRE  = 2'd1,
    RR_DROP    = 2'd2,
    RR_IDLE    = 2'd3
  } rr_cause_e;
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int NREQ  = 4,
  parameter int IDX_W = 2
) (
  input  logic [NREQ-1:0]  req,
  input  logic [IDX_W-1:0] base,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  // circular offset from base, wrapped into 0..NREQ-1
  function automatic logic [IDX_W-1:0] wrap_add(input logic [IDX_W-1:0] a,
                                                input int unsigned k);
    int unsigned s;
    s = 32'(a) + k;
    if (s >= NREQ) s = s - NREQ;
    return IDX_W'(s);
  endfunction

  always_comb begin
    found = 1'b0;
    idx   = '0;
    // walk from the far end back so the closest offset wins
    for (int k = NREQ - 1; k >= 0; k--) begin
      if (req[wrap_add(base, k)]) begin
        found = 1'b1;
        idx   = wrap_add(base, k);
      end
    end
  end
endmodule

// File: rtl/rr_slice_timer.sv
module rr_slice_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt,
  output logic             at_end
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  assign cnt    = cnt_q;
  assign at_end = &cnt_q;
endmodule

// File: rtl/rr_slice_arbiter.sv
module rr_slice_arbiter #(
  parameter int NREQ  = rr_pkg::RR_NREQ_DEFAULT,
  parameter int CNT_W = rr_pkg::RR_CNT_W_DEFAULT
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREQ-1:0] req,
  output logic [NREQ-1:0] grant
);
  localparam int IDX_W = (NREQ > 1) ? $clog2(NREQ) : 1;

  function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] i);
    int unsigned s;
    s = 32'(i) + 1;
    if (s >= NREQ) s = 0;
    return IDX_W'(s);
  endfunction

  function automatic logic [NREQ-1:0] to_onehot(input logic [IDX_W-1:0] i);
    return NREQ'(1) << i;
  endfunction

  logic [NREQ-1:0]  grant_q;
  logic [IDX_W-1:0] holder_q;
  logic [IDX_W-1:0] start_q;
  logic             busy_q;

  logic [CNT_W-1:0] slice_cnt;
  logic             slice_end;
  logic             slice_done;
  logic             holder_drop;
  logic             rearb;
  logic [IDX_W-1:0] search_base;
  logic             pick_found;
  logic [IDX_W-1:0] pick_idx;
  rr_pkg::rr_cause_e cause;

  // named internal events
  assign holder_drop = busy_q && !req[holder_q];
  assign slice_done  = busy_q && req[holder_q] && slice_end;
  assign rearb       = !busy_q || holder_drop || slice_end;
  assign search_base = busy_q ? next_idx(holder_q) : start_q;

  always_comb begin
    if (!busy_q)          cause = rr_pkg::RR_IDLE;
    else if (holder_drop) cause = rr_pkg::RR_DROP;
    else if (slice_end)   cause = rr_pkg::RR_EXPIRE;
    else                  cause = rr_pkg::RR_KEEP;
  end

  rr_pick #(.NREQ(NREQ), .IDX_W(IDX_W)) u_pick (
    .req   (req),
    .base  (search_base),
    .found (pick_found),
    .idx   (pick_idx)
  );

  rr_slice_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (rearb),
    .cnt     (slice_cnt),
    .at_end  (slice_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q  <= '0;
      holder_q <= '0;
      start_q  <= '0;
      busy_q   <= 1'b0;
    end else if (cause != rr_pkg::RR_KEEP) begin
      busy_q <= pick_found;
      if (pick_found) begin
        grant_q  <= to_onehot(pick_idx);
        holder_q <= pick_idx;
        start_q  <= next_idx(pick_idx);
      end else begin
        grant_q  <= '0;
      end
    end
  end

  assign grant = grant_q;
endmodule

// File: rtl/rr_slice_arbiter_chk.sv
module rr_slice_arbiter_chk #(
  parameter int NREQ  = 4,
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [NREQ-1:0]  req,
  input logic [NREQ-1:0]  grant,
  input logic [CNT_W-1:0] slice_cnt,
  input logic             holder_drop,
  input logic             slice_done
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (grant == '0) && (slice_cnt == '0));

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (req == '0) |=> (grant == '0));

  // R6
  early_release_chk: assert property (@(posedge clk) disable iff (rst)
    holder_drop |=> ((grant & $past(grant)) == '0));

  // R5
  hold_in_slice_chk: assert property (@(posedge clk) disable iff (rst)
    ((grant & req) != '0) && !slice_done |=> (grant == $past(grant)));

  // R5
  slice_rotate_chk: assert property (@(posedge clk) disable iff (rst)
    slice_done && ((req & ~grant) != '0) |=> (grant != $past(grant)));

  // R8
  sole_keep_chk: assert property (@(posedge clk) disable iff (rst)
    slice_done && (req == grant) |=> (grant == $past(grant)) && (slice_cnt == '0));

  // R7
  cnt_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (grant != '0) && !$stable(grant) |-> (slice_cnt == '0));
endmodule

bind rr_slice_arbiter rr_slice_arbiter_chk #(.NREQ(NREQ), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req         (req),
  .grant       (grant),
  .slice_cnt   (slice_cnt),
  .holder_drop (holder_drop),
  .slice_done  (slice_done)
);

// File: tb/rr_slice_arbiter_bench.sv
module rr_slice_arbiter_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] req = 4'b0000;
  logic [3:0] grant;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  string tag    = "R2";

  always #2 clk = ~clk;

  rr_slice_arbiter u_rr_slice_arbiter (
    .clk   (clk),
    .rst   (rst),
    .req   (req),
    .grant (grant)
  );

  // behavioural reference: current owner (-1 none), cycles held, last owner
  int m_hold = -1;
  int m_age  = 0;
  int m_last = 3;

  always @(posedge clk) begin
    if (rst) begin
      m_hold = -1; m_age = 0; m_last = 3;
    end else if (m_hold < 0 || !req[m_hold] || m_age == 3) begin
      int from;
      int pick;
      from = (m_hold >= 0) ? m_hold + 1 : m_last + 1;
      pick = -1;
      for (int k = 0; k < 4; k++) begin
        if (pick < 0 && req[(from + k) % 4]) pick = (from + k) % 4;
      end
      m_hold = pick;
      m_age  = 0;
      if (pick >= 0) m_last = pick;
    end else begin
      m_age = m_age + 1;
    end
  end

  function automatic logic [3:0] model_grant();
    return (m_hold < 0) ? 4'b0000 : 4'(1 << m_hold);
  endfunction

  task automatic chk(input string r, input logic [3:0] exp);
    checks++;
    if (grant !== exp) begin
      fails++;
      $display("FAIL %s grant=%b expected=%b at %0t", r, grant, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(tag, model_grant());
      checks++;
      if ($countones(grant) > 1) begin
        fails++;
        $display("FAIL R2 grant=%b expected=at most one bit", grant);
      end
    end
  end

  task automatic step(input logic [3:0] v);
    req = v;
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [3:0] r;
    repeat (3) @(negedge clk);
    chk("R1", 4'b0000);
    rst = 1'b0;
    tag = "R1";
    step(4'b0000); chk("R1", 4'b0000);

    // all request: requester 0 first, one cycle latency
    tag = "R5";
    step(4'b1111); chk("R3", 4'b0001);
    repeat (3) begin step(4'b1111); chk("R5", 4'b0001); end
    step(4'b1111); chk("R5", 4'b0010);

    // holder 1 drops right after winning
    tag = "R6";
    step(4'b1101); chk("R6", 4'b0100);
    tag = "R7";
    repeat (3) begin step(4'b1101); chk("R7", 4'b0100); end
    step(4'b1101); chk("R4", 4'b1000);
    repeat (3) begin step(4'b1101); chk("R4", 4'b1000); end
    step(4'b1101); chk("R4", 4'b0001);

    // sole requester keeps the grant across slices
    tag = "R8";
    repeat (10) begin step(4'b0001); chk("R8", 4'b0001); end

    // sole holder leaves, grant clears
    tag = "R6";
    step(4'b0000); chk("R6", 4'b0000);
    tag = "R2";
    step(4'b0000); chk("R2", 4'b0000);

    // resume after idle: search begins after last holder 0
    tag = "R9";
    step(4'b1111); chk("R9", 4'b0010);
    step(4'b0000); chk("R2", 4'b0000);
    step(4'b1001); chk("R9", 4'b1000);
    step(4'b0000); chk("R2", 4'b0000);

    // random sticky traffic against the model
    tag = "R4";
    r = 4'b0000;
    for (int n = 0; n < 4000; n++) begin
      for (int b = 0; b < 4; b++) begin
        if (($urandom % 6) == 0) r[b] = ~r[b];
      end
      step(r);
    end

    // reset in the middle of traffic
    tag = "R1";
    rst = 1'b1;
    step(4'b1111);
    chk("R1", 4'b0000);
    rst = 1'b0;
    step(4'b1111); chk("R1", 4'b0001);
    finish_run();
  end
endmodule